// File: doc/BRIEF.md
# Flash Command Unlock Decoder

This block sits between a host write port and the program/erase engine of a NOR-style flash. Each host write reaches it as one strobe that carries a full word address and a data word. The block looks for the standard multi-cycle unlock protocol. That means two fixed key writes, then a command byte, and for erases a second pair of keys followed by a final erase code. From this it produces single-cycle requests for word program, sector erase, block erase and chip erase, each with an aligned target address. It also holds two level flags: identification mode and query mode. While identification mode is active, a small read-out port returns the manufacturer and device codes.

Only the low 15 address bits and the low 8 data bits take part in the key and command comparisons. Any write that breaks the expected order discards the sequence. A busy input from the engine makes the decoder deaf to every write, the exit command included. An active-low write-protect input guards the four lowest 1K-word sectors against program and erase. For chip erase it only marks those sectors to be kept.

Top module: `flcmd_decoder`

## Requirements
- R1: A key write is data byte AAh at address 5555h (first key) or 55h at 2AAAh (second key). Only address bits 14:0 and data bits 7:0 are compared, and any other address or data value in these bits does not match.
- R2: The sequence first key, second key, A0h at 5555h, then any write W yields `prog_pulse` in the cycle after W's strobe edge, with `op_addr` and `op_data` equal to W's address and data.
- R3: The sequence first key, second key, 80h at 5555h, first key, second key, then a write W ends in one of two ways. If W's data byte is 30h, it gives `sect_erase_pulse` with `op_addr` equal to W's address with bits 9:0 cleared. If W's data byte is 50h, it gives `blk_erase_pulse` with `op_addr` equal to W's address with bits 14:0 cleared.
- R4: In the erase sequence of R3, a final write of 10h at 5555h gives `chip_erase_pulse` with `op_addr` equal to 0. In that same cycle `op_keep_low` is set to the inverse of `wp_n`.
- R5: A third write of 90h at 5555h after the two keys sets `id_mode`. While it is set, `ident_data` returns 00BFh one cycle after `rd_addr` equals 0, and 2761h one cycle after `rd_addr` equals 1. At any other address, or outside identification mode, it returns 0.
- R6: A third write of 98h at 5555h sets `query_mode` and clears `id_mode`. A third write of 90h clears `query_mode`. The two flags are never both set.
- R7: A third write of F0h at 5555h clears both `id_mode` and `query_mode`. Any other third-write byte that does not open a command leaves both flags unchanged.
- R8: A write that does not match the expected step returns the decoder to idle. That same write does not count as a new first key, so a sequence that falls out of step needs a fresh first key.
- R9: While `busy` is 1, strobes are ignored and any partial sequence is discarded. No pulse is produced and the mode flags do not change.
- R10: While `wp_n` is 0, the decoder blocks three requests: a program whose address is below 1000h, a sector erase whose sector index (address bits 19:10) is below 4, and a block erase of block 0 (address bits 19:15 equal to 0). A blocked request gives no pulse and leaves the decoder idle.
- R11: Synchronous active-high `rst` clears all pulses, both mode flags, `ident_data` and the sequence state.
- R12: At most one operation pulse is high in any cycle, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | 20 | Word address of the host write |
| wr_data | input | 16 | Data word of the host write |
| busy | input | 1 | Program/erase engine busy; writes ignored while high |
| wp_n | input | 1 | Active-low protection of the bottom four sectors |
| rd_addr | input | 20 | Read address for the identification read-out |
| prog_pulse | output | 1 | Word program request |
| sect_erase_pulse | output | 1 | Sector erase request |
| blk_erase_pulse | output | 1 | Block erase request |
| chip_erase_pulse | output | 1 | Chip erase request |
| op_addr | output | 20 | Target address of the last request, aligned for erases |
| op_data | output | 16 | Data word of the last program request |
| op_keep_low | output | 1 | Last chip erase must skip the protected sectors |
| id_mode | output | 1 | Identification mode active |
| query_mode | output | 1 | Query mode active |
| ident_data | output | 16 | Identification read-out data |

## Verification
The hardest cases to reach are the ones deep in the six-write erase path. These are a final write that is wrong, a protected block, and the busy input cutting a sequence that is already half accepted. Each needs five correct writes before the single write that matters. The bench reaches them with sweeps built on helper tasks that replay the full prefix. It sweeps all 256 values of the third and the sixth byte. It flips every compared address and data bit in the first key. It also walks the low sectors and blocks with protection on and off, so the idle state after each abort or block is checked through the next write.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  localparam int CMD_AW = 15;
  localparam int CMD_DW = 8;

  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [CMD_DW-1:0] KEY_DATA_A = 8'hAA;
  localparam logic [CMD_DW-1:0] KEY_DATA_B = 8'h55;

  localparam logic [CMD_DW-1:0] OP_PROG  = 8'hA0;
  localparam logic [CMD_DW-1:0] OP_ERASE = 8'h80;
  localparam logic [CMD_DW-1:0] OP_IDENT = 8'h90;
  localparam logic [CMD_DW-1:0] OP_QUERY = 8'h98;
  localparam logic [CMD_DW-1:0] OP_LEAVE = 8'hF0;
  localparam logic [CMD_DW-1:0] OP_SECT  = 8'h30;
  localparam logic [CMD_DW-1:0] OP_BLOCK = 8'h50;
  localparam logic [CMD_DW-1:0] OP_CHIP  = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERA1, ST_ERA2, ST_ERA3
  } seq_state_t;
endpackage

// File: rtl/flcmd_match.sv
module flcmd_match
  import flcmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit_key_a,
  output logic              hit_key_b,
  output logic              at_cmd_addr,
  output logic [CMD_DW-1:0] code
);
  logic [CMD_AW-1:0] low_addr;

  always_comb begin
    low_addr    = addr[CMD_AW-1:0];
    code        = data[CMD_DW-1:0];
    at_cmd_addr = (low_addr == KEY_ADDR_A);
    hit_key_a   = at_cmd_addr && (code == KEY_DATA_A);
    hit_key_b   = (low_addr == KEY_ADDR_B) && (code == KEY_DATA_B);
  end
endmodule

// File: rtl/flcmd_protect.sv
module flcmd_protect #(
  parameter int ADDR_W     = 20,
  parameter int SECT_W     = 10,
  parameter int BLK_W      = 15,
  parameter int PROT_SECTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  output logic              word_blocked,
  output logic              blk_blocked
);
  localparam int SIDX_W = ADDR_W - SECT_W;
  localparam int BIDX_W = ADDR_W - BLK_W;

  logic [SIDX_W-1:0] sect_idx;
  logic [SIDX_W-1:0] blk_first_sect;

  always_comb begin
    sect_idx       = addr[ADDR_W-1:SECT_W];
    blk_first_sect = SIDX_W'({addr[ADDR_W-1:BLK_W], {(BLK_W-SECT_W){1'b0}}});
    word_blocked   = !wp_n && (int'(sect_idx) < PROT_SECTS);
    blk_blocked    = !wp_n && (int'(blk_first_sect) < PROT_SECTS);
  end

  logic unused_bidx;
  assign unused_bidx = (BIDX_W == 0);
endmodule

// File: rtl/flcmd_ident.sv
module flcmd_ident #(
  parameter int              ADDR_W = 20,
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00BF,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h2761
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] ident_data
);
  logic at_base;
  assign at_base = (rd_addr[ADDR_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_data <= '0;
    end else if (id_mode && at_base) begin
      ident_data <= rd_addr[0] ? DEV_CODE : MFR_CODE;
    end else begin
      ident_data <= '0;
    end
  end
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
  import flcmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SECT_W     = 10,
  parameter int BLK_W      = 15,
  parameter int PROT_SECTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prog_pulse,
  output logic              sect_erase_pulse,
  output logic              blk_erase_pulse,
  output logic              chip_erase_pulse,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              op_keep_low,
  output logic              id_mode,
  output logic              query_mode,
  output logic [DATA_W-1:0] ident_data
);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECT_W) - 64'd1);
  localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((64'd1 << BLK_W) - 64'd1);

  seq_state_t        state;
  logic              hit_key_a, hit_key_b, at_cmd_addr;
  logic [CMD_DW-1:0] code;
  logic              word_blocked, blk_blocked;

  flcmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr(wr_addr), .data(wr_data),
    .hit_key_a(hit_key_a), .hit_key_b(hit_key_b),
    .at_cmd_addr(at_cmd_addr), .code(code)
  );

  flcmd_protect #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W),
                  .PROT_SECTS(PROT_SECTS)) u_protect (
    .addr(wr_addr), .wp_n(wp_n),
    .word_blocked(word_blocked), .blk_blocked(blk_blocked)
  );

  flcmd_ident #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ident (
    .clk(clk), .rst(rst), .id_mode(id_mode),
    .rd_addr(rd_addr), .ident_data(ident_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= ST_IDLE;
      prog_pulse       <= 1'b0;
      sect_erase_pulse <= 1'b0;
      blk_erase_pulse  <= 1'b0;
      chip_erase_pulse <= 1'b0;
      op_addr          <= '0;
      op_data          <= '0;
      op_keep_low      <= 1'b0;
      id_mode          <= 1'b0;
      query_mode       <= 1'b0;
    end else begin
      prog_pulse       <= 1'b0;
      sect_erase_pulse <= 1'b0;
      blk_erase_pulse  <= 1'b0;
      chip_erase_pulse <= 1'b0;
      if (busy) begin
        state <= ST_IDLE;
      end else if (wr_stb) begin
        state <= ST_IDLE;
        case (state)
          ST_IDLE: if (hit_key_a) state <= ST_KEY1;
          ST_KEY1: if (hit_key_b) state <= ST_KEY2;
          ST_KEY2: if (at_cmd_addr) begin
            case (code)
              OP_PROG:  state <= ST_PROG;
              OP_ERASE: state <= ST_ERA1;
              OP_IDENT: begin id_mode <= 1'b1; query_mode <= 1'b0; end
              OP_QUERY: begin id_mode <= 1'b0; query_mode <= 1'b1; end
              OP_LEAVE: begin id_mode <= 1'b0; query_mode <= 1'b0; end
              default: ;
            endcase
          end
          ST_PROG: if (!word_blocked) begin
            prog_pulse <= 1'b1;
            op_addr    <= wr_addr;
            op_data    <= wr_data;
          end
          ST_ERA1: if (hit_key_a) state <= ST_ERA2;
          ST_ERA2: if (hit_key_b) state <= ST_ERA3;
          ST_ERA3: begin
            case (code)
              OP_SECT: if (!word_blocked) begin
                sect_erase_pulse <= 1'b1;
                op_addr          <= wr_addr & ~SECT_MASK;
              end
              OP_BLOCK: if (!blk_blocked) begin
                blk_erase_pulse <= 1'b1;
                op_addr         <= wr_addr & ~BLK_MASK;
              end
              OP_CHIP: if (at_cmd_addr) begin
                chip_erase_pulse <= 1'b1;
                op_addr          <= '0;
                op_keep_low      <= !wp_n;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flcmd_checker.sv
module flcmd_checker #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SECT_W     = 10,
  parameter int PROT_SECTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic              busy,
  input logic              wp_n,
  input logic              prog_pulse,
  input logic              sect_erase_pulse,
  input logic              blk_erase_pulse,
  input logic              chip_erase_pulse,
  input logic [ADDR_W-1:0] op_addr,
  input logic              id_mode,
  input logic              query_mode
);
  logic any_pulse;
  assign any_pulse = prog_pulse | sect_erase_pulse | blk_erase_pulse | chip_erase_pulse;

  assert_one_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_pulse, sect_erase_pulse, blk_erase_pulse, chip_erase_pulse}));

  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (rst)
    any_pulse |=> !any_pulse);

  assert_pulse_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    any_pulse |-> $past(wr_stb));

  assert_busy_no_op_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !any_pulse);

  assert_busy_modes_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(id_mode) && $stable(query_mode)));

  assert_modes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(id_mode && query_mode));

  assert_prog_protect_R10: assert property (@(posedge clk) disable iff (rst)
    (prog_pulse && !$past(wp_n)) |-> (int'(op_addr[ADDR_W-1:SECT_W]) >= PROT_SECTS));

  assert_sect_protect_R10: assert property (@(posedge clk) disable iff (rst)
    (sect_erase_pulse && !$past(wp_n)) |-> (int'(op_addr[ADDR_W-1:SECT_W]) >= PROT_SECTS));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!id_mode && !query_mode && !any_pulse));
endmodule

bind flcmd_decoder flcmd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .PROT_SECTS(PROT_SECTS)
) u_flcmd_checker (.*);

// File: tb/flcmd_decoder_bench.sv
module flcmd_decoder_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          wp_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic          prog_pulse, sect_erase_pulse, blk_erase_pulse, chip_erase_pulse;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          op_keep_low, id_mode, query_mode;
  logic [DW-1:0] ident_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  flcmd_decoder u_flcmd_decoder (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .wp_n(wp_n), .rd_addr(rd_addr),
    .prog_pulse(prog_pulse), .sect_erase_pulse(sect_erase_pulse),
    .blk_erase_pulse(blk_erase_pulse), .chip_erase_pulse(chip_erase_pulse),
    .op_addr(op_addr), .op_data(op_data), .op_keep_low(op_keep_low),
    .id_mode(id_mode), .query_mode(query_mode), .ident_data(ident_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pulses();
    return {prog_pulse, sect_erase_pulse, blk_erase_pulse, chip_erase_pulse};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic keys();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic cmd(input logic [7:0] c);
    keys();
    wr(20'h05555, {8'h00, c});
  endtask

  task automatic erase_prefix();
    cmd(8'h80);
    keys();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 pulses after reset", 32'(pulses()), 0);
    chk("R11 modes after reset", {30'd0, id_mode, query_mode}, 0);
    chk("R11 ident after reset", 32'(ident_data), 0);

    // R2 R5 R6 R7 R8: sweep the third-cycle byte over all values
    for (int d = 0; d < 256; d++) begin
      logic exp_id, exp_q;
      logic [AW-1:0] pa;
      cmd(d[0] ? 8'h90 : 8'h98);
      exp_id = d[0]; exp_q = !d[0];
      cmd(8'(d));
      if (d == 8'h90) begin exp_id = 1; exp_q = 0; end
      else if (d == 8'h98) begin exp_id = 0; exp_q = 1; end
      else if (d == 8'hF0) begin exp_id = 0; exp_q = 0; end
      chk("R7 R6 modes after third byte", {30'd0, id_mode, query_mode}, {30'd0, exp_id, exp_q});
      chk("R8 no pulse on third byte", 32'(pulses()), 0);
      pa = 20'h80000 | AW'(d << 6);
      wr(pa, 16'hC000 | DW'(d));
      chk("R2 program pulse after fourth write", 32'(pulses()), (d == 8'hA0) ? 32'h8 : 0);
      if (d == 8'hA0) begin
        chk("R2 program address", 32'(op_addr), 32'(pa));
        chk("R2 program data", 32'(op_data), 32'(16'hC000 | d));
        @(negedge clk);
        chk("R12 pulse lasts one cycle", 32'(pulses()), 0);
      end
    end
    cmd(8'hF0);

    // R3 R4: sweep the sixth-cycle byte over all values
    for (int d = 0; d < 256; d++) begin
      logic [3:0] ep;
      logic [AW-1:0] ea;
      erase_prefix();
      wr(20'h45555, DW'(d) | 16'h7700);
      ep = (d == 8'h30) ? 4'h4 : (d == 8'h50) ? 4'h2 : (d == 8'h10) ? 4'h1 : 4'h0;
      ea = (d == 8'h30) ? 20'h45400 : (d == 8'h50) ? 20'h40000 : 20'h0;
      chk("R3 R4 erase pulse by sixth byte", 32'(pulses()), 32'(ep));
      if (ep != 0) chk("R3 R4 erase target address", 32'(op_addr), 32'(ea));
      if (d == 8'h10) chk("R4 keep-low flag with protection off", 32'(op_keep_low), 0);
    end

    // R4: chip erase needs 5555 on the sixth write, and keep-low follows wp_n
    erase_prefix();
    wr(20'h45556, 16'h0010);
    chk("R4 chip erase at wrong address", 32'(pulses()), 0);
    wp_n = 1'b0;
    erase_prefix();
    wr(20'h05555, 16'h0010);
    chk("R4 chip erase under protection", 32'(pulses()), 32'h1);
    chk("R4 keep-low flag set", 32'(op_keep_low), 1);
    wp_n = 1'b1;

    // R10: protection sweep over low sectors and blocks
    for (int w = 0; w < 2; w++) begin
      wp_n = w[0];
      for (int s = 0; s < 8; s++) begin
        logic ok;
        ok = (w == 1) || (s >= 4);
        cmd(8'hA0);
        wr(AW'(s * 1024 + 5), 16'h1357);
        chk("R10 program in sector", 32'(pulses()), ok ? 32'h8 : 0);
        wr(AW'(s * 1024 + 5), 16'h1357);
        chk("R10 idle after program attempt", 32'(pulses()), 0);
        erase_prefix();
        wr(AW'(s * 1024 + 3), 16'h0030);
        chk("R10 sector erase", 32'(pulses()), ok ? 32'h4 : 0);
      end
      for (int b = 0; b < 3; b++) begin
        erase_prefix();
        wr(AW'(b * 32768 + 16'h1234), 16'h0050);
        chk("R10 block erase", 32'(pulses()), ((w == 1) || (b != 0)) ? 32'h2 : 0);
      end
    end
    wp_n = 1'b1;

    // R1: every compared bit of the first key matters; upper bits do not
    for (int i = 0; i < 23; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] dd;
      a = 20'h05555; dd = 16'h00AA;
      if (i < 15) a[i] = ~a[i]; else dd[i-15] = ~dd[i-15];
      wr(a, dd);
      wr(20'h02AAA, 16'h0055);
      wr(20'h05555, 16'h00A0);
      wr(20'h90000, 16'h4242);
      chk("R1 corrupted first key", 32'(pulses()), 0);
    end
    wr(20'hF5555, 16'hFFAA);
    wr(20'hA2AAA, 16'h3C55);
    wr(20'h55555, 16'h99A0);
    wr(20'h90000, 16'h4242);
    chk("R1 upper bits ignored", 32'(pulses()), 32'h8);

    // R8: an out-of-step key is not a fresh start
    wr(20'h05555, 16'h00AA);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h90000, 16'h4242);
    chk("R8 no restart on mismatch", 32'(pulses()), 0);

    // R9: busy blocks commands, the exit command and partial sequences
    busy = 1'b1;
    cmd(8'hA0);
    wr(20'h90000, 16'h1111);
    chk("R9 program ignored while busy", 32'(pulses()), 0);
    busy = 1'b0;
    cmd(8'h90);
    busy = 1'b1;
    cmd(8'hF0);
    chk("R9 exit ignored while busy", 32'(id_mode), 1);
    busy = 1'b0;
    keys();
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    wr(20'h05555, 16'h00A0);
    wr(20'h90000, 16'h2222);
    chk("R9 partial sequence discarded", 32'(pulses()), 0);

    // R5: identification read-out
    rd_addr = 20'h0; @(negedge clk);
    chk("R5 manufacturer code", 32'(ident_data), 32'h00BF);
    rd_addr = 20'h1; @(negedge clk);
    chk("R5 device code", 32'(ident_data), 32'h2761);
    rd_addr = 20'h2; @(negedge clk);
    chk("R5 other address", 32'(ident_data), 0);
    cmd(8'hF0);
    rd_addr = 20'h1; @(negedge clk);
    chk("R5 code hidden outside mode", 32'(ident_data), 0);

    // R11: reset clears modes
    cmd(8'h98);
    chk("R6 query mode set", {30'd0, id_mode, query_mode}, 32'h1);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R11 reset clears modes", {30'd0, id_mode, query_mode}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule